// File: doc/BRIEF.md
# APB Multi-Port GPIO Register File

This block is the register side of a general-purpose I/O unit. It sits behind an APB slave port and serves up to four ports of up to 32 lines each. For every port it keeps an output-value register and an output-enable (direction) register, and it drives those values straight onto the pad-side pins. It also returns the current pin levels, after a two-flop synchronizer, through one read-only input-level register per port.

The interrupt-control registers of the first port are not stored here. The block decodes their offsets and passes each access to a separate interrupt unit. It sends an access strobe, a write flag, a register code and the write data. For reads it returns the interrupt unit's read data. A build-time parameter picks one of two address layouts for these interrupt registers. Every access completes in one cycle, and no access ever returns an error response.

Top module: `gpio_apb_regfile`

## Requirements
- R1: The output-value registers of ports 0..3 sit at byte offsets 0x00, 0x0c, 0x18 and 0x24. A write takes effect at the clock edge that ends the access phase. It appears on the port's slice of `pin_out` from the next cycle on, and the register reads back what was written.
- R2: The direction registers of ports 0..3 sit at byte offsets 0x04, 0x10, 0x1c and 0x28. A 1 bit makes the line an output, shown as a 1 on the matching `pin_oe` bit. A 0 bit makes it an input. The register reads back what was written.
- R3: The input-level registers of ports 0..3 are at 0x50, 0x54, 0x58 and 0x5c. They return `pin_in` through two flops. A level that is present at one rising edge is not yet visible after that edge alone, and it becomes readable after the second edge.
- R4: Writes to an input-level register have no effect. The output-value and direction registers and `pin_out`/`pin_oe` keep their values, and a read of that register still returns the synchronized pin level.
- R5: With `ALT_IRQ_MAP`=0 the interrupt registers are decoded at these offsets: 0x30 enable (code 0), 0x34 mask (code 1), 0x38 trigger-type (code 2), 0x3c polarity (code 3), 0x40 status (code 4), 0x48 debounce (code 5) and 0x4c end-of-interrupt (code 6). An access to one of them raises `irq_access` during the access phase and puts the code on `irq_id`.
- R6: With `ALT_IRQ_MAP`=1 the offsets change as follows: 0x30 enable (code 0), 0x34 trigger-type (code 2), 0x38 polarity (code 3), 0x3c status (code 4), 0x40 end-of-interrupt (code 6), 0x44 mask (code 1) and 0x48 debounce (code 5). Offset 0x4c is unmapped in this layout, and 0x44 is unmapped in the default layout.
- R7: For an interrupt-register access, `irq_write` equals `pwrite` and `irq_wdata` carries `pwdata`. A read returns `irq_rdata` on `prdata` in the same cycle.
- R8: A read returns zero when its offset is unmapped. Unmapped offsets are the gaps 0x08/0x14/0x20/0x2c, offsets of absent ports, offsets above 0x5c and any offset whose two low bits are not zero. `pready` is always 1 and `pslverr` is always 0.
- R9: After reset every writable register is zero, so `pin_out` and `pin_oe` are all zero and every line is an input.
- R10: Register bits at or above `LINES_PER_PORT` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pin_in | input | NUM_PORTS*LINES_PER_PORT | Raw pin levels, port 0 in the low slice |
| pin_out | output | NUM_PORTS*LINES_PER_PORT | Output values for the pads |
| pin_oe | output | NUM_PORTS*LINES_PER_PORT | Output enables for the pads |
| irq_access | output | 1 | Access phase hits an interrupt register |
| irq_write | output | 1 | That access is a write |
| irq_id | output | 3 | Interrupt register code |
| irq_wdata | output | 32 | Write data for the interrupt unit |
| irq_rdata | input | 32 | Read data from the interrupt unit |

## Verification
The hardest case to reach from the ports is the exact latency of the synchronizer. The read has to land after one edge and then after two edges from a pin change. The stimulus changes `pin_in` in the same half-cycle as a read's setup phase, so that read's access phase sees the old level. The read that follows must see the new one. The two interrupt layouts run side by side: a second instance with the other map shares the bus, so each offset is checked against both decodes in the same access.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

   localparam int MAX_PORTS   = 4;
   localparam int MAX_LINES   = 32;
   localparam int SYNC_DEPTH  = 2;

   // word index (byte offset / 4) of fixed landmarks
   localparam int LAST_PAIR_WORD = 11;   // 0x2c, last slot of the 3-word port stride
   localparam int PAIR_STRIDE_W  = 3;    // 12-byte stride in words
   localparam int EXT_BASE_WORD  = 20;   // 0x50

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_DATA = 3'd1,
      K_DIR  = 3'd2,
      K_EXT  = 3'd3,
      K_IRQ  = 3'd4
   } kind_t;

   typedef enum logic [2:0] {
      IRQ_ENABLE   = 3'd0,
      IRQ_MASK     = 3'd1,
      IRQ_TRIGTYPE = 3'd2,
      IRQ_POLARITY = 3'd3,
      IRQ_STATUS   = 3'd4,
      IRQ_DEBOUNCE = 3'd5,
      IRQ_EOI      = 3'd6
   } irq_id_t;

   typedef struct packed {
      kind_t      kind;
      logic [1:0] port;
      irq_id_t    irq;
   } hit_t;

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
   import gpio_rf_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int NUM_PORTS   = 4,
   parameter bit ALT_IRQ_MAP = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   int unsigned       w;
   logic              irq_hit;
   irq_id_t           irq_code;

   assign word = addr[ADDR_W-1:2];
   assign w    = 32'(word);

   // the interrupt layout is a build-time choice
   generate
      if (ALT_IRQ_MAP) begin : g_alt_map
         always_comb begin
            irq_hit  = 1'b1;
            irq_code = IRQ_ENABLE;
            case (w)
               12:      irq_code = IRQ_ENABLE;
               13:      irq_code = IRQ_TRIGTYPE;
               14:      irq_code = IRQ_POLARITY;
               15:      irq_code = IRQ_STATUS;
               16:      irq_code = IRQ_EOI;
               17:      irq_code = IRQ_MASK;
               18:      irq_code = IRQ_DEBOUNCE;
               default: irq_hit  = 1'b0;
            endcase
         end
      end else begin : g_base_map
         always_comb begin
            irq_hit  = 1'b1;
            irq_code = IRQ_ENABLE;
            case (w)
               12:      irq_code = IRQ_ENABLE;
               13:      irq_code = IRQ_MASK;
               14:      irq_code = IRQ_TRIGTYPE;
               15:      irq_code = IRQ_POLARITY;
               16:      irq_code = IRQ_STATUS;
               18:      irq_code = IRQ_DEBOUNCE;
               19:      irq_code = IRQ_EOI;
               default: irq_hit  = 1'b0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      hit      = '0;
      hit.kind = K_NONE;
      hit.irq  = irq_code;
      if (addr[1:0] != 2'b00) begin
         hit.kind = K_NONE;
      end else if (w <= LAST_PAIR_WORD) begin
         hit.port = 2'(w / PAIR_STRIDE_W);
         case (w % PAIR_STRIDE_W)
            0:       hit.kind = K_DATA;
            1:       hit.kind = K_DIR;
            default: hit.kind = K_NONE;
         endcase
      end else if (w >= EXT_BASE_WORD && w < EXT_BASE_WORD + MAX_PORTS) begin
         hit.port = 2'(w - EXT_BASE_WORD);
         hit.kind = K_EXT;
      end else if (irq_hit) begin
         hit.kind = K_IRQ;
      end
      // port-indexed registers of absent ports are holes
      if ((hit.kind == K_DATA || hit.kind == K_DIR || hit.kind == K_EXT) &&
          32'(hit.port) >= NUM_PORTS)
         hit.kind = K_NONE;
   end

endmodule

// File: rtl/gpio_rf_port.sv
module gpio_rf_port
   import gpio_rf_pkg::*;
#(
   parameter int LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we,
   input  logic             dir_we,
   input  logic [LINES-1:0] wdata,
   input  logic [LINES-1:0] pin_in,
   output logic [LINES-1:0] data_q,
   output logic [LINES-1:0] dir_q,
   output logic [LINES-1:0] ext_q
);

   logic [LINES-1:0] sync_q [SYNC_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (data_we) data_q <= wdata;
         if (dir_we)  dir_q  <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_DEPTH; i++) sync_q[i] <= '0;
      end else begin
         sync_q[0] <= pin_in;
         for (int i = 1; i < SYNC_DEPTH; i++) sync_q[i] <= sync_q[i-1];
      end
   end

   assign ext_q = sync_q[SYNC_DEPTH-1];

endmodule

// File: rtl/gpio_apb_regfile.sv
module gpio_apb_regfile
   import gpio_rf_pkg::*;
#(
   parameter int ADDR_W         = 7,
   parameter int NUM_PORTS      = 4,
   parameter int LINES_PER_PORT = 32,
   parameter bit ALT_IRQ_MAP    = 1'b0
) (
   input  logic                                pclk,
   input  logic                                presetn,
   input  logic                                psel,
   input  logic                                penable,
   input  logic                                pwrite,
   input  logic [ADDR_W-1:0]                   paddr,
   input  logic [31:0]                         pwdata,
   output logic [31:0]                         prdata,
   output logic                                pready,
   output logic                                pslverr,
   input  logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_in,
   output logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_out,
   output logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_oe,
   output logic                                irq_access,
   output logic                                irq_write,
   output logic [2:0]                          irq_id,
   output logic [31:0]                         irq_wdata,
   input  logic [31:0]                         irq_rdata
);

   localparam int LW = LINES_PER_PORT;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
         $error("NUM_PORTS must be 1..4");
      end
      if (LW < 1 || LW > MAX_LINES) begin : g_bad_lines
         $error("LINES_PER_PORT must be 1..32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x5c");
      end
   endgenerate

   hit_t    hit;
   logic    access;
   logic    wr;
   logic [LW-1:0] data_arr [MAX_PORTS];
   logic [LW-1:0] dir_arr  [MAX_PORTS];
   logic [LW-1:0] ext_arr  [MAX_PORTS];
   logic [31:0]   rd_word;

   assign access = psel & penable;
   assign wr     = access & pwrite;

   gpio_rf_decode #(
      .ADDR_W     (ADDR_W),
      .NUM_PORTS  (NUM_PORTS),
      .ALT_IRQ_MAP(ALT_IRQ_MAP)
   ) u_decode (
      .addr(paddr),
      .hit (hit)
   );

   generate
      for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
         if (p < NUM_PORTS) begin : g_live
            logic data_we, dir_we;
            assign data_we = wr && hit.kind == K_DATA && 32'(hit.port) == p;
            assign dir_we  = wr && hit.kind == K_DIR  && 32'(hit.port) == p;

            gpio_rf_port #(.LINES(LW)) u_port (
               .clk    (pclk),
               .rst_n  (presetn),
               .data_we(data_we),
               .dir_we (dir_we),
               .wdata  (pwdata[LW-1:0]),
               .pin_in (pin_in[p*LW +: LW]),
               .data_q (data_arr[p]),
               .dir_q  (dir_arr[p]),
               .ext_q  (ext_arr[p])
            );

            assign pin_out[p*LW +: LW] = data_arr[p];
            assign pin_oe [p*LW +: LW] = dir_arr[p];
         end else begin : g_absent
            assign data_arr[p] = '0;
            assign dir_arr[p]  = '0;
            assign ext_arr[p]  = '0;
         end
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      case (hit.kind)
         K_DATA:  rd_word[LW-1:0] = data_arr[hit.port];
         K_DIR:   rd_word[LW-1:0] = dir_arr[hit.port];
         K_EXT:   rd_word[LW-1:0] = ext_arr[hit.port];
         K_IRQ:   rd_word         = irq_rdata;
         default: rd_word         = '0;
      endcase
   end

   assign prdata     = (psel && !pwrite) ? rd_word : 32'd0;
   assign pready     = 1'b1;
   assign pslverr    = 1'b0;

   assign irq_access = access && hit.kind == K_IRQ;
   assign irq_write  = irq_access && pwrite;
   assign irq_id     = hit.irq;
   assign irq_wdata  = pwdata;

endmodule

// File: rtl/gpio_rf_checker.sv
module gpio_rf_checker #(
   parameter int ADDR_W         = 7,
   parameter int NUM_PORTS      = 4,
   parameter int LINES_PER_PORT = 32,
   parameter bit ALT_IRQ_MAP    = 1'b0
) (
   input logic                                pclk,
   input logic                                presetn,
   input logic                                psel,
   input logic                                penable,
   input logic                                pwrite,
   input logic [ADDR_W-1:0]                   paddr,
   input logic [31:0]                         pwdata,
   input logic [31:0]                         prdata,
   input logic                                pready,
   input logic                                pslverr,
   input logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_in,
   input logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_out,
   input logic [NUM_PORTS*LINES_PER_PORT-1:0] pin_oe,
   input logic                                irq_access,
   input logic                                irq_write,
   input logic [2:0]                          irq_id,
   input logic [31:0]                         irq_wdata,
   input logic [31:0]                         irq_rdata
);

   localparam int LW = LINES_PER_PORT;

   logic       acc;
   logic [1:0] since_rst;

   assign acc = psel && penable;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1
   assert_data_reaches_pins_R1: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && paddr == ADDR_W'(8'h00)) |=>
         pin_out[LW-1:0] == $past(pwdata[LW-1:0]));

   // R2
   assert_dir_reaches_oe_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && paddr == ADDR_W'(8'h04)) |=>
         pin_oe[LW-1:0] == $past(pwdata[LW-1:0]));

   // R3
   assert_sync_latency_R3: assert property (@(posedge pclk) disable iff (!presetn)
      (since_rst == 2'd3 && acc && !pwrite && paddr == ADDR_W'(8'h50)) |->
         prdata[LW-1:0] == $past(pin_in[LW-1:0], 2));

   // R4 and R1/R2: pins move only on a write
   assert_pins_hold_R4: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc && pwrite) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R5/R6: enable sits at 0x30 in both layouts
   assert_enable_decode_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && paddr == ADDR_W'(8'h30)) |-> (irq_access && irq_id == 3'd0));

   // R7
   assert_irq_forward_R7: assert property (@(posedge pclk) disable iff (!presetn)
      irq_access |-> (irq_write == pwrite && irq_wdata == pwdata &&
                      (pwrite || prdata == irq_rdata)));

   // R8
   assert_gap_reads_zero_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && paddr == ADDR_W'(8'h08)) |-> prdata == 32'd0);

   assert_no_wait_no_err_R8: assert property (@(posedge pclk) disable iff (!presetn)
      pready && !pslverr);

   // R9
   assert_idle_after_reset_R9: assert property (@(posedge pclk)
      !presetn |=> (pin_oe == '0 && pin_out == '0));

endmodule

bind gpio_apb_regfile gpio_rf_checker #(
   .ADDR_W        (ADDR_W),
   .NUM_PORTS     (NUM_PORTS),
   .LINES_PER_PORT(LINES_PER_PORT),
   .ALT_IRQ_MAP   (ALT_IRQ_MAP)
) u_rf_checker (
   .pclk      (pclk),
   .presetn   (presetn),
   .psel      (psel),
   .penable   (penable),
   .pwrite    (pwrite),
   .paddr     (paddr),
   .pwdata    (pwdata),
   .prdata    (prdata),
   .pready    (pready),
   .pslverr   (pslverr),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_access(irq_access),
   .irq_write (irq_write),
   .irq_id    (irq_id),
   .irq_wdata (irq_wdata),
   .irq_rdata (irq_rdata)
);

// File: tb/gpio_apb_regfile_bench.sv
module gpio_apb_regfile_bench;

   localparam int AW = 7;
   localparam int NP = 3;
   localparam int LW = 24;
   localparam int PW = NP * LW;

   logic          clk = 1'b0;
   logic          rstn = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   irq_rdata = 32'hC0DE_5A17;
   logic [PW-1:0] pin_in = '0;

   logic [31:0]   prdata, prdata_a, irq_wdata, irq_wdata_a;
   logic          pready, pslverr, pready_a, pslverr_a;
   logic [PW-1:0] pin_out, pin_oe, pin_out_a, pin_oe_a;
   logic          irq_access, irq_write, irq_access_a, irq_write_a;
   logic [2:0]    irq_id, irq_id_a;

   int checks = 0;
   int fails  = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   // access-phase snapshot
   logic        s_acc, s_wr, s_ready, s_err, a_acc;
   logic [2:0]  s_id, a_id;
   logic [31:0] s_wdata;

   always #10 clk = ~clk;   // 50 MHz

   gpio_apb_regfile #(.ADDR_W(AW), .NUM_PORTS(NP), .LINES_PER_PORT(LW), .ALT_IRQ_MAP(1'b0))
   u_gpio_apb_regfile (
      .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_access(irq_access), .irq_write(irq_write), .irq_id(irq_id),
      .irq_wdata(irq_wdata), .irq_rdata(irq_rdata)
   );

   gpio_apb_regfile #(.ADDR_W(AW), .NUM_PORTS(NP), .LINES_PER_PORT(LW), .ALT_IRQ_MAP(1'b1))
   u_gpio_apb_regfile_alt (
      .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a),
      .pin_in(pin_in), .pin_out(pin_out_a), .pin_oe(pin_oe_a),
      .irq_access(irq_access_a), .irq_write(irq_write_a), .irq_id(irq_id_a),
      .irq_wdata(irq_wdata_a), .irq_rdata(irq_rdata)
   );

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // monitor: pops the expected read data at every read access phase
   always begin
      @(negedge clk);
      #5;
      if (psel && penable && !pwrite) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL monitor: unexpected read, got %h expected none", prdata);
         end else begin
            chk(prdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic access(input logic [AW-1:0] a, input logic w, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #5;
      s_acc = irq_access; s_wr = irq_write; s_id = irq_id; s_wdata = irq_wdata;
      s_ready = pready; s_err = pslverr; a_acc = irq_access_a; a_id = irq_id_a;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      access(a, 1'b1, d);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      access(a, 1'b0, 32'd0);
   endtask

   // checks interrupt decode of both layouts at one offset
   task automatic irq_probe(input logic [AW-1:0] a, input logic bv, input logic [2:0] bid,
                            input logic av, input logic [2:0] aid);
      rd(a, bv ? irq_rdata : 32'd0, "R7 irq read data");
      chk({31'd0, s_acc}, {31'd0, bv}, "R5 base map hit");
      if (bv) chk({29'd0, s_id}, {29'd0, bid}, "R5 base map code");
      chk({31'd0, a_acc}, {31'd0, av}, "R6 alt map hit");
      if (av) chk({29'd0, a_id}, {29'd0, aid}, "R6 alt map code");
   endtask

   initial begin
      #(200000 * 20);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rstn = 1'b1;
      @(negedge clk);

      // R9: reset state
      chk(pin_oe[31:0], 32'd0, "R9 pin_oe after reset");
      chk(pin_out[31:0], 32'd0, "R9 pin_out after reset");
      rd(7'h00, 32'd0, "R9 data reg reset");
      rd(7'h1c, 32'd0, "R9 dir reg reset");

      // R1 / R10: data registers
      wr(7'h00, 32'hFFFF_FFFF);
      chk({8'd0, pin_out[23:0]}, 32'h00FF_FFFF, "R1 port0 pin_out");
      rd(7'h00, 32'h00FF_FFFF, "R10 upper bits read zero");
      wr(7'h0c, 32'h0012_3456);
      wr(7'h18, 32'h00A5_5A0F);
      chk({8'd0, pin_out[47:24]}, 32'h0012_3456, "R1 port1 pin_out");
      chk({8'd0, pin_out[71:48]}, 32'h00A5_5A0F, "R1 port2 pin_out");
      rd(7'h0c, 32'h0012_3456, "R1 port1 readback");

      // R2: direction registers
      wr(7'h10, 32'h0000_F00F);
      chk({8'd0, pin_oe[47:24]}, 32'h0000_F00F, "R2 port1 pin_oe");
      chk({8'd0, pin_oe[23:0]}, 32'd0, "R2 port0 still input");
      rd(7'h10, 32'h0000_F00F, "R2 readback");

      // R8: holes, absent port, unaligned, high offsets
      rd(7'h08, 32'd0, "R8 gap 0x08");
      rd(7'h24, 32'd0, "R8 absent port data");
      rd(7'h5c, 32'd0, "R8 absent port ext");
      rd(7'h60, 32'd0, "R8 above map");
      rd(7'h01, 32'd0, "R8 unaligned");
      chk({30'd0, s_ready, s_err}, 32'd2, "R8 pready/pslverr");

      // R3: latency through the synchronizer
      @(negedge clk);
      pin_in[47:24] = 24'hABCDEF;
      exp_q.push_back(32'd0); tag_q.push_back("R3 not visible after one edge");
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 7'h54;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
      rd(7'h54, 32'h00AB_CDEF, "R3 visible after two edges");
      pin_in[23:0] = 24'h00_1234;
      repeat (2) @(negedge clk);
      rd(7'h50, 32'h0000_1234, "R3 port0 level");

      // R4: writing an input-level register changes nothing
      wr(7'h54, 32'h0000_0000);
      wr(7'h50, 32'hFFFF_FFFF);
      rd(7'h54, 32'h00AB_CDEF, "R4 ext still shows pin");
      chk({8'd0, pin_out[47:24]}, 32'h0012_3456, "R4 pin_out kept");
      chk({8'd0, pin_oe[47:24]}, 32'h0000_F00F, "R4 pin_oe kept");
      rd(7'h00, 32'h00FF_FFFF, "R4 data reg kept");

      // R5 / R6 / R7: interrupt decode in both layouts
      irq_probe(7'h30, 1'b1, 3'd0, 1'b1, 3'd0);
      irq_probe(7'h34, 1'b1, 3'd1, 1'b1, 3'd2);
      irq_probe(7'h38, 1'b1, 3'd2, 1'b1, 3'd3);
      irq_probe(7'h3c, 1'b1, 3'd3, 1'b1, 3'd4);
      irq_probe(7'h40, 1'b1, 3'd4, 1'b1, 3'd6);
      irq_probe(7'h44, 1'b0, 3'd0, 1'b1, 3'd1);
      irq_probe(7'h48, 1'b1, 3'd5, 1'b1, 3'd5);
      irq_probe(7'h4c, 1'b1, 3'd6, 1'b0, 3'd0);
      irq_rdata = 32'h1357_9BDF;
      irq_probe(7'h3c, 1'b1, 3'd3, 1'b1, 3'd4);

      wr(7'h4c, 32'hDEAD_0042);
      chk({31'd0, s_acc}, 32'd1, "R7 write strobe");
      chk({31'd0, s_wr}, 32'd1, "R7 write flag");
      chk(s_wdata, 32'hDEAD_0042, "R7 write data");
      chk({8'd0, pin_out[23:0]}, 32'h00FF_FFFF, "R7 irq write leaves port0");

      @(negedge clk);
      chk(exp_q.size(), 32'd0, "scoreboard drained");
      summary();
   end

endmodule